// File: doc/BRIEF.md
# Peripheral DMA Request Router

This block sits between a set of peripherals and a bank of DMA channels. Every channel owns a 16-bit map word that says what the channel serves. A map word either names one peripheral, through a 4-bit index in its top nibble, or marks the channel as a memory-to-memory channel. A memory channel works as one half of a pair with its neighbour. When a peripheral raises its request line, the router finds the lowest-numbered peripheral channel whose index equals that peripheral. It then gives that channel's interrupt line a one-cycle pulse.

Map words are loaded through a simple write port and take computed defaults at reset. Several requests can arrive in the same cycle. They are held pending and served one per cycle, lowest peripheral index first. A request that finds no channel raises an error pulse. A query port reads back any channel's map word, its memory flag and the number of its paired channel. A per-channel flag marks peripheral channels whose index points past the last peripheral.

Top module: `dmamap_router`

## Requirements
- R1: After reset, channel c below MEM_BASE holds map word ((c mod NUM_PERIPH) << 12). Channel c at or above MEM_BASE holds 16'h0040, which has only the memory flag, bit 6, set. After reset, ch_irq and err_nomap are low.
- R2: When wr_en is high at a clock edge, wr_data is stored as the map word of channel wr_ch. It is visible on q_map from the next cycle.
- R3: A request line req[p] that is high at clock edge t is captured as pending at that edge. At edge t+1, exactly one ch_irq bit goes high for one cycle, or err_nomap does. Bits 15:12 of the map word are the peripheral index.
- R4: When several peripheral channels hold index p, the lowest-numbered one receives the interrupt.
- R5: A channel whose map bit 6 is set is a memory channel. It never receives a peripheral interrupt, whatever its index bits hold.
- R6: When no peripheral channel holds index p, a request from p gives a one-cycle err_nomap pulse, and ch_irq stays all-zero for that service cycle.
- R7: Requests that are pending at the same time are served one per cycle in ascending peripheral index. Requests not yet served stay pending, and at most one pending request is retired per cycle.
- R8: For the channel on q_ch, q_peer equals q_ch with bit 0 flipped. q_is_mem equals bit 6 of that channel's map word.
- R9: bad_cfg[c] is high exactly when channel c is a peripheral channel (bit 6 clear) whose index is NUM_PERIPH or more. Such a channel never receives an interrupt.
- R10: At most one bit of ch_irq is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Map word write strobe |
| wr_ch | input | CH_W (4) | Channel whose map word is written |
| wr_data | input | 16 | New map word |
| req | input | NUM_PERIPH (12) | Request lines from the peripherals, one per index |
| q_ch | input | CH_W (4) | Channel selected for the query port |
| q_map | output | 16 | Map word of the queried channel |
| q_is_mem | output | 1 | Queried channel is a memory channel |
| q_peer | output | CH_W (4) | Paired channel number of the queried channel |
| bad_cfg | output | NUM_CH (16) | Per-channel flag for an out-of-range peripheral index |
| ch_irq | output | NUM_CH (16) | Per-channel interrupt pulse |
| err_nomap | output | 1 | Pulse: the served request matched no channel |

## Verification
The hardest case to reach is a burst in which several pending requests are served back to back over successive cycles. In the same burst, some of the requests must resolve to channels shadowed by lower duplicates and some to no channel at all. The stimulus builds this by rewriting random map words, with stray reserved bits, out-of-range indices and memory flags mixed in. It then fires multi-bit request vectors, and the expected channel for each cycle comes from a shadow copy of the map words. Directed cases come first: shadowing a channel, turning the lower duplicate into a memory channel, and leaving a default memory channel whose index bits alias peripheral 0.

// File: rtl/dmamap_pkg.sv
package dmamap_pkg;

    localparam int MAP_W   = 16;
    localparam int IDX_LSB = 12;
    localparam int IDX_W   = MAP_W - IDX_LSB;
    localparam int MEM_BIT = 6;

    typedef logic [MAP_W-1:0] map_word_t;
    typedef logic [IDX_W-1:0] idx_t;

    // Field view of one map word.
    typedef struct packed {
        idx_t                          idx;
        logic [IDX_LSB-MEM_BIT-2:0]    rsvd_hi;
        logic                          mem;
        logic [MEM_BIT-1:0]            rsvd_lo;
    } map_fields_t;

    // Default map word for a channel after reset.
    function automatic map_word_t reset_map(int ch, int mem_base, int n_periph);
        map_word_t w;
        if (ch < mem_base) begin
            w = map_word_t'((ch % n_periph) << IDX_LSB);
        end else begin
            w = map_word_t'(1) << MEM_BIT;
        end
        return w;
    endfunction

    function automatic logic is_bad_index(map_fields_t f, int n_periph);
        return (!f.mem) && (int'(f.idx) >= n_periph);
    endfunction

endpackage

// File: rtl/dmamap_regs.sv
module dmamap_regs
    import dmamap_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int NUM_PERIPH = 12,
    parameter int MEM_BASE   = 12,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [CH_W-1:0]           wr_ch,
    input  map_word_t                 wr_data,
    output map_word_t [NUM_CH-1:0]    maps,
    output idx_t      [NUM_CH-1:0]    idx_vec,
    output logic      [NUM_CH-1:0]    mem_vec,
    output logic      [NUM_CH-1:0]    bad_vec
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam map_word_t RST_WORD = reset_map(g, MEM_BASE, NUM_PERIPH);
        map_word_t   word_q;
        map_fields_t fld;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= RST_WORD;
            end else if (wr_en && (wr_ch == CH_W'(g))) begin
                word_q <= wr_data;
            end
        end

        assign fld        = map_fields_t'(word_q);
        assign maps[g]    = word_q;
        assign idx_vec[g] = fld.idx;
        assign mem_vec[g] = fld.mem;
        assign bad_vec[g] = is_bad_index(fld, NUM_PERIPH);
    end

endmodule

// File: rtl/dmamap_pend.sv
module dmamap_pend #(
    parameter int NUM_PERIPH = 12,
    localparam int P_W       = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PERIPH-1:0] req,
    output logic [NUM_PERIPH-1:0] pend,
    output logic                  sel_valid,
    output logic [P_W-1:0]        sel_idx
);

    logic [NUM_PERIPH-1:0] pend_q;
    logic [NUM_PERIPH-1:0] grant;

    // Lowest pending index wins.
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        for (int p = NUM_PERIPH - 1; p >= 0; p--) begin
            if (pend_q[p]) begin
                sel_valid = 1'b1;
                sel_idx   = P_W'(p);
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PERIPH; p++) begin
            grant[p] = sel_valid && (sel_idx == P_W'(p));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~grant) | req;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/dmamap_lookup.sv
module dmamap_lookup
    import dmamap_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  idx_t [NUM_CH-1:0] idx_vec,
    input  logic [NUM_CH-1:0] mem_vec,
    input  idx_t              want,
    output logic              hit,
    output logic [CH_W-1:0]   hit_ch
);

    // Scan from the top so the lowest matching channel is kept last.
    always_comb begin
        hit    = 1'b0;
        hit_ch = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (!mem_vec[c] && (idx_vec[c] == want)) begin
                hit    = 1'b1;
                hit_ch = CH_W'(c);
            end
        end
    end

endmodule

// File: rtl/dmamap_router.sv
module dmamap_router
    import dmamap_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int NUM_PERIPH = 12,
    parameter int MEM_BASE   = 12,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int P_W       = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CH_W-1:0]       wr_ch,
    input  logic [MAP_W-1:0]      wr_data,
    input  logic [NUM_PERIPH-1:0] req,
    input  logic [CH_W-1:0]       q_ch,
    output logic [MAP_W-1:0]      q_map,
    output logic                  q_is_mem,
    output logic [CH_W-1:0]       q_peer,
    output logic [NUM_CH-1:0]     bad_cfg,
    output logic [NUM_CH-1:0]     ch_irq,
    output logic                  err_nomap
);

    map_word_t [NUM_CH-1:0] maps;
    idx_t      [NUM_CH-1:0] idx_vec;
    logic      [NUM_CH-1:0] mem_vec;
    logic [NUM_PERIPH-1:0]  pend_vec;
    logic                   sel_valid;
    logic [P_W-1:0]         sel_idx;
    logic                   hit;
    logic [CH_W-1:0]        hit_ch;
    logic [NUM_CH-1:0]      irq_nx;

    dmamap_regs #(
        .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH), .MEM_BASE(MEM_BASE)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .maps(maps), .idx_vec(idx_vec), .mem_vec(mem_vec), .bad_vec(bad_cfg)
    );

    dmamap_pend #(.NUM_PERIPH(NUM_PERIPH)) u_pend (
        .clk(clk), .rst(rst), .req(req),
        .pend(pend_vec), .sel_valid(sel_valid), .sel_idx(sel_idx)
    );

    dmamap_lookup #(.NUM_CH(NUM_CH)) u_lookup (
        .idx_vec(idx_vec), .mem_vec(mem_vec), .want(idx_t'(sel_idx)),
        .hit(hit), .hit_ch(hit_ch)
    );

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            irq_nx[c] = sel_valid && hit && (hit_ch == CH_W'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_irq    <= '0;
            err_nomap <= 1'b0;
        end else begin
            ch_irq    <= irq_nx;
            err_nomap <= sel_valid && !hit;
        end
    end

    // Query port: map word, memory flag and paired channel.
    assign q_map    = maps[q_ch];
    assign q_is_mem = q_map[MEM_BIT];
    assign q_peer   = q_ch ^ CH_W'(1);

endmodule

// File: rtl/dmamap_router_chk.sv
module dmamap_router_chk #(
    parameter int NUM_CH     = 16,
    parameter int NUM_PERIPH = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_CH-1:0]     ch_irq,
    input logic                  err_nomap,
    input logic [NUM_CH-1:0]     bad_cfg,
    input logic [NUM_CH-1:0]     mem_vec,
    input logic [NUM_PERIPH-1:0] pend_vec
);

    p_irq_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_irq));

    p_irq_err_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !((|ch_irq) && err_nomap));

    p_service_follows_pend_r3: assert property (@(posedge clk) disable iff (rst)
        (|$past(pend_vec)) == ((|ch_irq) || err_nomap));

    p_one_retire_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0($past(pend_vec) & ~pend_vec));

    p_mem_skip_r5: assert property (@(posedge clk) disable iff (rst)
        (ch_irq & $past(mem_vec)) == '0);

    p_bad_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (ch_irq & $past(bad_cfg)) == '0);

endmodule

bind dmamap_router dmamap_router_chk #(
    .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)
) u_chk (
    .clk(clk), .rst(rst), .ch_irq(ch_irq), .err_nomap(err_nomap),
    .bad_cfg(bad_cfg), .mem_vec(mem_vec), .pend_vec(pend_vec)
);

// File: tb/dmamap_router_bench.sv
`timescale 1ns/1ps
module dmamap_router_bench;

    localparam int NCH = 16;
    localparam int NP  = 12;
    localparam int MB  = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_ch = '0;
    logic [15:0] wr_data = '0;
    logic [NP-1:0] req = '0;
    logic [3:0]  q_ch = '0;
    logic [15:0] q_map;
    logic        q_is_mem;
    logic [3:0]  q_peer;
    logic [NCH-1:0] bad_cfg;
    logic [NCH-1:0] ch_irq;
    logic        err_nomap;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [15:0] sh [NCH];

    always #5 clk = ~clk;

    dmamap_router u_dmamap_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .req(req), .q_ch(q_ch), .q_map(q_map), .q_is_mem(q_is_mem),
        .q_peer(q_peer), .bad_cfg(bad_cfg), .ch_irq(ch_irq), .err_nomap(err_nomap)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] dflt(int c);
        return (c < MB) ? 16'((c % NP) << 12) : 16'h0040;
    endfunction

    function automatic int target(int p);
        for (int c = 0; c < NCH; c++)
            if (!sh[c][6] && int'(sh[c][15:12]) == p) return c;
        return -1;
    endfunction

    function automatic logic [NCH-1:0] exp_bad();
        logic [NCH-1:0] b;
        for (int c = 0; c < NCH; c++) b[c] = !sh[c][6] && (sh[c][15:12] >= 4'(NP));
        return b;
    endfunction

    task automatic wr(int c, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 4'(c); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        sh[c] = d;
    endtask

    // Drive a request vector for one cycle, then check each service cycle.
    task automatic fire(logic [NP-1:0] v, string tag);
        @(negedge clk);
        req = v;
        @(negedge clk);
        req = '0;
        for (int p = 0; p < NP; p++) begin
            if (v[p]) begin
                int t;
                t = target(p);
                @(negedge clk);
                if (t >= 0) begin
                    chk({tag, " irq"}, 32'(ch_irq), 32'(1) << t);
                    chk({tag, " err"}, 32'(err_nomap), 32'd0);
                end else begin
                    chk({tag, " irq(nomap) R6"}, 32'(ch_irq), 32'd0);
                    chk({tag, " err(nomap) R6"}, 32'(err_nomap), 32'd1);
                end
            end
        end
        @(negedge clk);
        chk({tag, " idle-irq R3"}, 32'(ch_irq), 32'd0);
        chk({tag, " idle-err R3"}, 32'(err_nomap), 32'd0);
    endtask

    task automatic restore();
        for (int c = 0; c < NCH; c++) wr(c, dflt(c));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < NCH; c++) sh[c] = dflt(c);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq at reset", 32'(ch_irq), 32'd0);
        chk("R1 err at reset", 32'(err_nomap), 32'd0);
        chk("R9 bad_cfg at reset", 32'(bad_cfg), 32'd0);
        for (int c = 0; c < NCH; c++) begin
            q_ch = 4'(c);
            #1;
            chk($sformatf("R1 map ch%0d", c), 32'(q_map), 32'(dflt(c)));
            chk($sformatf("R8 peer ch%0d", c), 32'(q_peer), 32'(c ^ 1));
            chk($sformatf("R8 mem ch%0d", c), 32'(q_is_mem), 32'(c >= MB));
        end

        // R3: single request on default map
        fire(12'(1) << 5, "R3 p5");

        // R4: channel 9 duplicates index 3; lower channel 3 wins
        wr(9, 16'h3000);
        q_ch = 4'd9; #1;
        chk("R2 readback ch9", 32'(q_map), 32'h3000);
        fire(12'(1) << 3, "R4 dup p3");

        // R5: channel 3 becomes memory type with index 3 kept; channel 9 serves
        wr(3, 16'h3040);
        q_ch = 4'd3; #1;
        chk("R8 mem flag ch3", 32'(q_is_mem), 32'd1);
        chk("R8 peer ch3", 32'(q_peer), 32'd2);
        fire(12'(1) << 3, "R5 memskip p3");

        // R5/R6: ch0 moved away; memory channels with index 0 must not match
        wr(0, 16'h7000);
        fire(12'(1) << 0, "R6 p0 none");

        // R9: out-of-range index on a peripheral channel, and on a memory channel
        wr(0, 16'hD000);
        wr(14, 16'hF040);
        @(negedge clk);
        chk("R9 bad ch0 only", 32'(bad_cfg), 32'h0001);
        fire(12'(1) << 1, "R9 p1 ok");

        // R7: burst served ascending
        restore();
        fire(12'b0100_0001_0010, "R7 burst");
        fire(12'hFFF, "R7 all");

        // Random mixes
        for (int it = 0; it < 150; it++) begin
            int nw;
            nw = 1 + int'($urandom % 4);
            for (int k = 0; k < nw; k++) begin
                int c;
                logic [3:0] ix;
                logic m;
                c  = int'($urandom % NCH);
                ix = ($urandom % 8 == 0) ? 4'(12 + $urandom % 4) : 4'($urandom % NP);
                m  = ($urandom % 5 == 0);
                wr(c, {ix, 5'($urandom), m, 6'($urandom)});
            end
            q_ch = 4'($urandom % NCH);
            @(negedge clk);
            chk("R2 random readback", 32'(q_map), 32'(sh[q_ch]));
            chk("R8 random mem", 32'(q_is_mem), 32'(sh[q_ch][6]));
            chk("R9 random bad", 32'(bad_cfg), 32'(exp_bad()));
            fire(12'($urandom), "R7 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule